// File: doc/BRIEF.md
# I2C Target Address Front End

This block sits between the pads of an I2C target and its local logic. It looks at the sampled SCL and SDA levels and cleans each one with a filter that needs agreeing samples. From the clean levels it finds START, repeated START and STOP conditions, and it keeps a flag that shows when a transfer is in progress. It then collects the address byte and decides whether to acknowledge it. The bus drivers are modelled as open-drain pull-down requests.

The acknowledge decision can follow two rules, and each has its own enable. One rule matches the target's own address. The other matches the general call address. When an address is accepted, the block holds SCL low for as long as the local side reports that it is not ready. It drives the ACK once the local side is ready.

A START always puts the block back into address collection, wherever that START falls. A short burst of bus noise cannot leave the block in a state where it stops answering its address. Data bytes after the address phase are not handled here.

Top module: `i2c_tgt_frontend`

## Requirements
- R1: A line level is taken up only after two consecutive clock samples agree. An SDA low pulse that lasts a single clock period on an idle bus leaves `busy_o` at 0.
- R2: A START (SDA falling while SCL is high) sets `busy_o`. A STOP (SDA rising while SCL is high) clears it. Both take effect on the fourth rising clock edge after the raw line change.
- R3: The address byte is shifted in on SCL rising edges, MSB first: seven address bits, then a direction bit (1 = read). On an accepted address, `rnw_o` takes the direction bit and holds it until the next accepted address.
- R4: When `ack_en_i`=1 and the seven address bits equal `own_addr_i`, `sda_drive_o` is asserted while SCL is low after the eighth bit. It is released on the SCL fall that ends the ninth clock.
- R5: When `ack_en_i`=0, the own address is not acknowledged. No `sda_drive_o` and no `match_stb_o` follow.
- R6: Address 0000000 with direction bit 0 is acknowledged only when `gc_en_i`=1. In that case `match_gc_o` goes to 1. An accepted own address sets `match_gc_o` to 0.
- R7: From the SCL fall after the eighth bit of an accepted address, `scl_hold_o` is asserted. It stays asserted while `ready_i` is 0, and until one clock after `sda_drive_o` rises.
- R8: After an address that is not accepted, or after the ninth clock of an accepted one, SDA is not driven until the next START.
- R9: A START or repeated START anywhere, including in the middle of a byte or after an acknowledged address, restarts address collection from bit one.
- R10: An SDA low pulse on an idle bus that is long enough to pass the filter does not stop the next correctly addressed transfer from being acknowledged.
- R11: `match_stb_o` is a single-clock pulse, issued in the first clock in which the ACK is driven.
- R12: While reset is asserted, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Sampled SCL level |
| sda_i | input | 1 | Sampled SDA level |
| own_addr_i | input | 7 | Own target address; change only while not busy |
| ack_en_i | input | 1 | Acknowledge the own address |
| gc_en_i | input | 1 | Acknowledge the general call address |
| ready_i | input | 1 | Local side can accept the transfer |
| scl_hold_o | output | 1 | Pull SCL low (clock stretch request) |
| sda_drive_o | output | 1 | Pull SDA low (ACK) |
| busy_o | output | 1 | Transfer in progress |
| match_stb_o | output | 1 | Address accepted, one-clock pulse |
| match_gc_o | output | 1 | Last accepted address was a general call |
| rnw_o | output | 1 | Direction bit of the last accepted address |

## Verification
A raw line change reaches the filtered level on the third rising edge. The condition or edge it forms acts on the state on the fourth rising edge. `busy_o`, `sda_drive_o`, `scl_hold_o`, `match_stb_o`, `match_gc_o` and `rnw_o` all change on that fourth edge.

The reference model in the bench takes the bus level a few nanoseconds after each falling edge and predicts the state that the next rising edge produces. The outputs are then compared 2 ns after that rising edge, so each expected value is checked in the very cycle it is due. Directed checks read the ACK the way a master does, in the middle of the ninth SCL high phase.

// File: rtl/i2c_tgt_pkg.sv
package i2c_tgt_pkg;
  localparam int unsigned ADDR_W     = 7;
  localparam int unsigned FRAME_BITS = ADDR_W + 1;
  localparam int unsigned CNT_W      = $clog2(FRAME_BITS + 1);
  localparam logic [ADDR_W-1:0] GC_ADDR = '0;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_HOLD,
    ST_ACK,
    ST_SKIP
  } tgt_state_e;
endpackage

// File: rtl/i2c_tgt_deglitch.sv
module i2c_tgt_deglitch #(
  parameter int unsigned NSAMP   = 2,
  parameter logic        RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_i,
  output logic line_o
);
  logic [NSAMP-1:0] hist_q, hist_d;
  logic             lvl_q, lvl_d;
  logic             agree;

  always_comb begin
    hist_d = {hist_q[NSAMP-2:0], line_i};
    agree  = (&hist_q) | ~(|hist_q);
    lvl_d  = agree ? hist_q[0] : lvl_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hist_q <= {NSAMP{RST_VAL}};
      lvl_q  <= RST_VAL;
    end else begin
      hist_q <= hist_d;
      lvl_q  <= lvl_d;
    end
  end

  assign line_o = lvl_q;

  // R1
  filt_agree_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (line_o != $past(line_o)) |-> ($past(line_i, 2) == line_o));
endmodule

// File: rtl/i2c_tgt_cond.sv
module i2c_tgt_cond (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_f,
  input  logic sda_f,
  output logic start_o,
  output logic stop_o,
  output logic rise_o,
  output logic fall_o
);
  logic scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_f;
      sda_q <= sda_f;
    end
  end

  always_comb begin
    start_o = scl_f & scl_q & sda_q & ~sda_f;
    stop_o  = scl_f & scl_q & ~sda_q & sda_f;
    rise_o  = scl_f & ~scl_q;
    fall_o  = ~scl_f & scl_q;
  end
endmodule

// File: rtl/i2c_tgt_addr_fsm.sv
module i2c_tgt_addr_fsm
  import i2c_tgt_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic              rise_i,
  input  logic              fall_i,
  input  logic              scl_f,
  input  logic              sda_f,
  input  logic [ADDR_W-1:0] own_addr_i,
  input  logic              ack_en_i,
  input  logic              gc_en_i,
  input  logic              ready_i,
  output logic              busy_o,
  output logic              sda_drive_o,
  output logic              scl_hold_o,
  output logic              match_stb_o,
  output logic              match_gc_o,
  output logic              rnw_o
);
  tgt_state_e            state_q, state_d;
  logic [CNT_W-1:0]      cnt_q, cnt_d;
  logic [FRAME_BITS-1:0] sh_q, sh_d;
  logic                  stb_q, stb_d;
  logic                  gc_q, gc_d;
  logic                  rnw_q, rnw_d;
  logic [ADDR_W-1:0]     addr_w;
  logic                  dir_w, hit_own, hit_gc, frame_done;

  always_comb begin
    addr_w     = sh_q[FRAME_BITS-1:1];
    dir_w      = sh_q[0];
    hit_own    = ack_en_i && (addr_w == own_addr_i);
    hit_gc     = gc_en_i && (addr_w == GC_ADDR) && !dir_w;
    frame_done = (cnt_q == CNT_W'(FRAME_BITS));
    state_d = state_q;
    cnt_d   = cnt_q;
    sh_d    = sh_q;
    stb_d   = 1'b0;
    gc_d    = gc_q;
    rnw_d   = rnw_q;
    if (start_i) begin
      state_d = ST_ADDR;
      cnt_d   = '0;
      sh_d    = '0;
    end else if (stop_i) begin
      state_d = ST_IDLE;
    end else begin
      unique case (state_q)
        ST_ADDR: begin
          if (rise_i && !frame_done) begin
            sh_d  = {sh_q[FRAME_BITS-2:0], sda_f};
            cnt_d = cnt_q + CNT_W'(1);
          end else if (fall_i && frame_done) begin
            if (hit_own || hit_gc) begin
              state_d = ST_HOLD;
              gc_d    = hit_gc;
              rnw_d   = dir_w;
            end else begin
              state_d = ST_SKIP;
            end
          end
        end
        ST_HOLD: begin
          if (ready_i) begin
            state_d = ST_ACK;
            stb_d   = 1'b1;
          end
        end
        ST_ACK: begin
          if (fall_i) state_d = ST_SKIP;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      sh_q    <= '0;
      stb_q   <= 1'b0;
      gc_q    <= 1'b0;
      rnw_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      sh_q    <= sh_d;
      stb_q   <= stb_d;
      gc_q    <= gc_d;
      rnw_q   <= rnw_d;
    end
  end

  assign busy_o      = (state_q != ST_IDLE);
  assign sda_drive_o = (state_q == ST_ACK);
  assign scl_hold_o  = (state_q == ST_HOLD) | stb_q;
  assign match_stb_o = stb_q;
  assign match_gc_o  = gc_q;
  assign rnw_o       = rnw_q;

  // R2
  start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> busy_o);
  // R2
  stop_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_i && !start_i) |=> !busy_o);
  // R9
  restart_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> (state_q == ST_ADDR) && (cnt_q == '0));
  // R4
  ack_scl_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_drive_o) |-> !scl_f);
  // R7
  ack_under_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_drive_o) |-> scl_hold_o);
  // R11
  stb_with_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    match_stb_o |-> sda_drive_o);
endmodule

// File: rtl/i2c_tgt_frontend.sv
module i2c_tgt_frontend
  import i2c_tgt_pkg::*;
#(
  parameter int unsigned NSAMP = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  input  logic [ADDR_W-1:0] own_addr_i,
  input  logic              ack_en_i,
  input  logic              gc_en_i,
  input  logic              ready_i,
  output logic              scl_hold_o,
  output logic              sda_drive_o,
  output logic              busy_o,
  output logic              match_stb_o,
  output logic              match_gc_o,
  output logic              rnw_o
);
  localparam int unsigned NLINES = 2;

  logic [1:0]        rsync_q;
  logic              rst_int_n;
  logic [NLINES-1:0] raw_w, filt_w;
  logic              start_w, stop_w, rise_w, fall_w;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_int_n = rsync_q[1];

  assign raw_w = {scl_i, sda_i};

  for (genvar g = 0; g < NLINES; g++) begin : g_line
    i2c_tgt_deglitch #(.NSAMP(NSAMP), .RST_VAL(1'b1)) u_flt (
      .clk    (clk),
      .rst_n  (rst_int_n),
      .line_i (raw_w[g]),
      .line_o (filt_w[g])
    );
  end

  i2c_tgt_cond u_cond (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .scl_f   (filt_w[1]),
    .sda_f   (filt_w[0]),
    .start_o (start_w),
    .stop_o  (stop_w),
    .rise_o  (rise_w),
    .fall_o  (fall_w)
  );

  i2c_tgt_addr_fsm u_fsm (
    .clk         (clk),
    .rst_n       (rst_int_n),
    .start_i     (start_w),
    .stop_i      (stop_w),
    .rise_i      (rise_w),
    .fall_i      (fall_w),
    .scl_f       (filt_w[1]),
    .sda_f       (filt_w[0]),
    .own_addr_i  (own_addr_i),
    .ack_en_i    (ack_en_i),
    .gc_en_i     (gc_en_i),
    .ready_i     (ready_i),
    .busy_o      (busy_o),
    .sda_drive_o (sda_drive_o),
    .scl_hold_o  (scl_hold_o),
    .match_stb_o (match_stb_o),
    .match_gc_o  (match_gc_o),
    .rnw_o       (rnw_o)
  );
endmodule

// File: tb/i2c_tgt_frontend_tb.sv
module i2c_tgt_frontend_tb;
  timeunit 1ns;
  timeprecision 1ps;

  localparam int Q     = 8;
  localparam int STALL = 20;
  localparam int P_FREE = 0, P_SHIFT = 1, P_WAIT = 2, P_ACK = 3, P_IGNORE = 4;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n;
  logic scl_m, sda_m;
  logic [6:0] own;
  logic ack_en, gc_en;
  logic ready_w = 1'b1;
  logic scl_bus, sda_bus;
  logic scl_hold_o, sda_drive_o, busy_o, match_stb_o, match_gc_o, rnw_o;

  int n_chk = 0, n_bad = 0;
  bit done = 0;
  bit cmp_on = 0;
  bit stall_on = 0;
  int held = 0;
  int stb_cnt = 0;

  assign scl_bus = scl_m & ~scl_hold_o;
  assign sda_bus = sda_m & ~sda_drive_o;

  i2c_tgt_frontend u_dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_bus), .sda_i(sda_bus),
    .own_addr_i(own), .ack_en_i(ack_en), .gc_en_i(gc_en), .ready_i(ready_w),
    .scl_hold_o(scl_hold_o), .sda_drive_o(sda_drive_o), .busy_o(busy_o),
    .match_stb_o(match_stb_o), .match_gc_o(match_gc_o), .rnw_o(rnw_o)
  );

  task automatic check(input string req, input string what,
                       input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", req, what, act, exp, $time);
    end
  endtask

  // local side: not ready for STALL held cycles when stalling is requested
  always @(negedge clk) begin
    if (!stall_on) held = 0;
    else if (scl_hold_o) held++;
    ready_w = !stall_on || (held >= STALL);
    if (match_stb_o) stb_cnt++;
  end

  // ---------------- reference model ----------------
  bit rq_scl[$], rq_sda[$], fq_scl[$], fq_sda[$];
  int ph = P_FREE, nbits = 0, val = 0;
  bit m_stb = 0, m_gc = 0, m_rnw = 0;

  task automatic model_step();
    bit nscl, nsda, c_scl, p_scl, c_sda, p_sda, st, sp, rs, fl, dir;
    int adr;
    if (!rst_n) begin
      rq_scl = '{1, 1, 1}; rq_sda = '{1, 1, 1};
      fq_scl = '{1, 1, 1}; fq_sda = '{1, 1, 1};
      ph = P_FREE; nbits = 0; val = 0; m_stb = 0; m_gc = 0; m_rnw = 0;
      return;
    end
    rq_scl.push_front(scl_bus); void'(rq_scl.pop_back());
    rq_sda.push_front(sda_bus); void'(rq_sda.pop_back());
    nscl = (rq_scl[1] == rq_scl[2]) ? rq_scl[1] : fq_scl[0];
    nsda = (rq_sda[1] == rq_sda[2]) ? rq_sda[1] : fq_sda[0];
    fq_scl.push_front(nscl); void'(fq_scl.pop_back());
    fq_sda.push_front(nsda); void'(fq_sda.pop_back());
    c_scl = fq_scl[1]; p_scl = fq_scl[2];
    c_sda = fq_sda[1]; p_sda = fq_sda[2];
    st = c_scl && p_scl && p_sda && !c_sda;
    sp = c_scl && p_scl && !p_sda && c_sda;
    rs = c_scl && !p_scl;
    fl = !c_scl && p_scl;
    m_stb = 0;
    if (st) begin
      ph = P_SHIFT; nbits = 0; val = 0;
    end else if (sp) begin
      ph = P_FREE;
    end else if (ph == P_SHIFT) begin
      if (rs && nbits < 8) begin
        val = val * 2 + int'(c_sda); nbits++;
      end else if (fl && nbits == 8) begin
        adr = val / 2; dir = val[0];
        if ((ack_en && adr == int'(own)) || (gc_en && adr == 0 && !dir)) begin
          ph = P_WAIT; m_gc = gc_en && adr == 0 && !dir; m_rnw = dir;
        end else ph = P_IGNORE;
      end
    end else if (ph == P_WAIT) begin
      if (ready_w) begin ph = P_ACK; m_stb = 1; end
    end else if (ph == P_ACK) begin
      if (fl) ph = P_IGNORE;
    end
  endtask

  always begin
    @(negedge clk); #2;
    model_step();
    @(posedge clk); #2;
    if (cmp_on && !done) begin
      check("R2",  "busy",      busy_o,      ph != P_FREE);
      check("R4",  "sda_drive", sda_drive_o, ph == P_ACK);
      check("R7",  "scl_hold",  scl_hold_o,  (ph == P_WAIT) || m_stb);
      check("R11", "match_stb", match_stb_o, m_stb);
      check("R3",  "rnw",       rnw_o,       m_rnw);
      check("R6",  "match_gc",  match_gc_o,  m_gc);
    end
  end

  // ---------------- master tasks ----------------
  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic scl_up();
    scl_m = 1'b1;
    while (scl_bus !== 1'b1) @(negedge clk);
  endtask

  task automatic bit_out(input bit b, output bit seen);
    sda_m = b; wait_cyc(Q);
    scl_up(); wait_cyc(Q / 2);
    seen = sda_bus; wait_cyc(Q / 2);
    scl_m = 1'b0; wait_cyc(Q);
  endtask

  task automatic start_c();
    sda_m = 1'b1; wait_cyc(Q);
    scl_up(); wait_cyc(Q);
    sda_m = 1'b0; wait_cyc(Q);
    scl_m = 1'b0; wait_cyc(Q);
  endtask

  task automatic stop_c();
    sda_m = 1'b0; wait_cyc(Q);
    scl_up(); wait_cyc(Q);
    sda_m = 1'b1; wait_cyc(Q);
  endtask

  task automatic send_byte(input logic [7:0] v, output bit acked);
    bit s;
    for (int i = 7; i >= 0; i--) bit_out(v[i], s);
    bit_out(1'b1, s);
    acked = !s;
  endtask

  function automatic logic [7:0] frame(input logic [6:0] a, input bit rd);
    return {a, rd};
  endfunction

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      summary();
      $finish;
    end
  end

  initial begin
    bit ak;
    bit s;
    int c0;
    rst_n = 1'b0; scl_m = 1'b1; sda_m = 1'b1;
    own = 7'h5A; ack_en = 1'b1; gc_en = 1'b0;
    wait_cyc(5);
    check("R12", "reset busy",  busy_o, 0);
    check("R12", "reset drive", sda_drive_o, 0);
    check("R12", "reset hold",  scl_hold_o, 0);
    check("R12", "reset flags", {match_stb_o, match_gc_o, rnw_o}, 0);
    rst_n = 1'b1;
    wait_cyc(6);
    cmp_on = 1;

    // R1: single-clock SDA low pulse on idle bus is rejected
    sda_m = 1'b0; wait_cyc(1); sda_m = 1'b1; wait_cyc(10);
    check("R1", "busy after 1-cycle glitch", busy_o, 0);

    // R4/R11/R3/R2: own address write
    c0 = stb_cnt;
    start_c();
    check("R2", "busy after start", busy_o, 1);
    send_byte(frame(7'h5A, 0), ak);
    check("R4", "own address acked", ak, 1);
    check("R11", "one strobe", stb_cnt - c0, 1);
    check("R3", "rnw write", rnw_o, 0);
    send_byte(frame(7'h5A, 0), ak);
    check("R8", "no ack on following byte", ak, 0);
    stop_c(); wait_cyc(6);
    check("R2", "busy after stop", busy_o, 0);

    // R3: read direction
    start_c(); send_byte(frame(7'h5A, 1), ak);
    check("R3", "read acked", ak, 1);
    check("R3", "rnw read", rnw_o, 1);
    stop_c(); wait_cyc(6);

    // R8: mismatch, then own pattern as data
    start_c(); send_byte(frame(7'h33, 0), ak);
    check("R8", "mismatch nacked", ak, 0);
    send_byte(frame(7'h5A, 0), ak);
    check("R8", "ignored until start", ak, 0);
    stop_c(); wait_cyc(6);

    // R5: own address with acknowledge disabled
    ack_en = 1'b0; c0 = stb_cnt;
    start_c(); send_byte(frame(7'h5A, 0), ak);
    check("R5", "own nacked when disabled", ak, 0);
    check("R5", "no strobe", stb_cnt - c0, 0);
    stop_c(); wait_cyc(6);
    ack_en = 1'b1;

    // R6: general call
    start_c(); send_byte(frame(7'h00, 0), ak);
    check("R6", "gc nacked when disabled", ak, 0);
    stop_c(); wait_cyc(6);
    gc_en = 1'b1;
    start_c(); send_byte(frame(7'h00, 0), ak);
    check("R6", "gc acked when enabled", ak, 1);
    check("R6", "gc flag", match_gc_o, 1);
    stop_c(); wait_cyc(6);
    start_c(); send_byte(frame(7'h5A, 0), ak);
    check("R6", "gc flag cleared by own", match_gc_o, 0);
    stop_c(); wait_cyc(6);
    gc_en = 1'b0;

    // R7: clock stretch while not ready
    stall_on = 1; wait_cyc(3);
    start_c(); send_byte(frame(7'h5A, 0), ak);
    check("R7", "acked after stretch", ak, 1);
    check("R7", "stretch lasted", held >= STALL, 1);
    stop_c(); wait_cyc(6);
    stall_on = 0; wait_cyc(3);

    // R9: repeated start in the middle of a byte
    start_c();
    bit_out(1, s); bit_out(0, s); bit_out(1, s);
    start_c();
    send_byte(frame(7'h5A, 0), ak);
    check("R9", "acked after mid-byte restart", ak, 1);
    // R9: repeated start after acknowledged address
    start_c();
    send_byte(frame(7'h5A, 1), ak);
    check("R9", "acked after second start", ak, 1);
    check("R9", "rnw from second address", rnw_o, 1);
    stop_c(); wait_cyc(6);

    // R10: filtered stray SDA pulse on idle bus
    sda_m = 1'b0; wait_cyc(5); sda_m = 1'b1; wait_cyc(10);
    check("R10", "bus free after stray pulse", busy_o, 0);
    start_c(); send_byte(frame(7'h5A, 0), ak);
    check("R10", "acked after stray pulse", ak, 1);
    stop_c(); wait_cyc(10);

    done = 1;
    summary();
    $finish;
  end
endmodule